// File: doc/BRIEF.md
# ADC Start Sequencer

This block decides when an analog-to-digital conversion begins. Five start sources reach it: a compare unit's special event, a trigger from a charge-time measurement unit, a timer event, a real-time-clock event and a software start strobe. The compare event counts only when that unit's mode field selects the trigger mode. The charge-time trigger counts only when its own trigger enable is set. Any source that passes its qualifier starts a conversion. This happens only while the converter is enabled and no conversion is already underway.

An accepted start raises a busy flag. The block then runs a programmable acquisition period on a down-counter and, when that period ends, sends a single-cycle start strobe to the converter core. The converter reports its finish on a done input. The busy flag then drops and a one-cycle interrupt request is raised. A qualified compare event also clears the partner timer on every occurrence, even when the converter is disabled. With the acquisition code at zero, acquisition timing is left to software and the strobe leaves at once. The exception is a pending sleep entry, which holds the strobe back by one instruction cycle.

All pins are plain control and status signals, and none of them uses a handshake. The requests are level-sampled on each rising clock edge. Nothing at the block's edge applies back-pressure: a request that cannot be taken is dropped.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, go_busy, conv_start, tmr_clear and irq are all 0.
- R2: A request starts a conversion only when it is qualified. The compare request (cmp_evt) needs cmp_mode equal to 4'b1011. The charge-time request (ctu_evt) needs ctu_trig_en set. The tmr_evt, rtc_evt and sw_go requests need no qualifier. An accepted start drives go_busy to 1 on the next clock edge.
- R3: While adc_en is 0, every request is ignored and go_busy stays 0.
- R4: Each cmp_evt that arrives with cmp_mode equal to 4'b1011 gives a tmr_clear pulse on the next edge. This holds whatever the values of adc_en and go_busy.
- R5: A nonzero acquisition code k is sampled on acq_sel in the accepting cycle. conv_start is then a single-cycle pulse, rising exactly k*ACQ_UNIT cycles after go_busy rises.
- R6: With acq_sel equal to 3'b000 and sleep_pending equal to 0 in the accepting cycle, conv_start rises in the same cycle as go_busy.
- R7: With acq_sel equal to 3'b000 and sleep_pending equal to 1 in the accepting cycle, conv_start rises INSTR_CLKS cycles after go_busy.
- R8: conv_done sampled after conv_start has issued gives, on the next edge, go_busy of 0 and an irq pulse one cycle long. conv_done sampled at any other time has no effect.
- R9: A request that arrives while go_busy is 1 is ignored. Several requests in the same cycle produce one conv_start only.
- R10: Clearing adc_en cancels acquisition or conversion. On the next edge go_busy is 0, and neither irq nor conv_start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_en | input | 1 | Converter enable |
| sw_go | input | 1 | Software start strobe |
| cmp_evt | input | 1 | Compare-unit special event |
| cmp_mode | input | 4 | Compare-unit mode field |
| ctu_evt | input | 1 | Charge-time unit trigger |
| ctu_trig_en | input | 1 | Charge-time trigger enable |
| tmr_evt | input | 1 | Timer trigger |
| rtc_evt | input | 1 | Real-time-clock trigger |
| acq_sel | input | 3 | Acquisition length code |
| sleep_pending | input | 1 | Sleep entry is about to happen |
| conv_done | input | 1 | Converter core finished |
| go_busy | output | 1 | Go/done flag |
| conv_start | output | 1 | Start-convert strobe to the core |
| tmr_clear | output | 1 | Clear for the compare partner timer |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
An internal fault shows on the pins within a bounded and short window. If the acquisition counter loads the wrong length, conv_start rises a measurable number of cycles early or late after go_busy. If the sequencer state is wrong, conv_start appears twice or not at all. It also shows as an irq that comes without a finished conversion, or as a go_busy that stays high after done or after the enable has dropped. Each of these is visible within one edge of the event that caused it, or at the latest after the longest acquisition window of 7*ACQ_UNIT cycles. A qualifier gate that is wrong shows at once as go_busy or tmr_clear taking the wrong value on the edge after the request.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACQ  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_t;

  localparam logic [3:0] CMP_TRIG_MODE = 4'b1011;
  localparam int         N_SRC         = 5;
endpackage

// File: rtl/trig_qualify.sv
module trig_qualify
  import adc_trig_pkg::*;
(
  input  logic       adc_en,
  input  logic       sw_go,
  input  logic       cmp_evt,
  input  logic [3:0] cmp_mode,
  input  logic       ctu_evt,
  input  logic       ctu_trig_en,
  input  logic       tmr_evt,
  input  logic       rtc_evt,
  output logic       cmp_hit,
  output logic       start_req
);
  logic [N_SRC-1:0] raw;
  logic [N_SRC-1:0] qual;
  logic [N_SRC-1:0] ok;

  assign cmp_hit = cmp_evt && (cmp_mode == CMP_TRIG_MODE);

  assign raw  = {sw_go, rtc_evt, tmr_evt, ctu_evt, cmp_evt};
  assign qual = {1'b1, 1'b1, 1'b1, ctu_trig_en, (cmp_mode == CMP_TRIG_MODE)};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign ok[i] = raw[i] & qual[i];
  end

  assign start_req = adc_en && (|ok);
endmodule

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int ACQ_UNIT   = 2,
  parameter int INSTR_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       sleep,
  output logic       bypass,
  output logic       last
);
  localparam int MAX_ACQ = 7 * ACQ_UNIT;
  localparam int MAX_LEN = (MAX_ACQ > INSTR_CLKS) ? MAX_ACQ : INSTR_CLKS;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_len;

  always_comb begin
    if (sel == 3'b000) load_len = CW'(INSTR_CLKS);
    else               load_len = CW'(int'(sel) * ACQ_UNIT);
  end

  assign bypass = (sel == 3'b000) && !sleep;
  assign last   = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_len;
    else if (run && cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/start_seq.sv
module start_seq
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic start_req,
  input  logic bypass,
  input  logic acq_last,
  input  logic conv_done,
  output logic load,
  output logic run,
  output logic go_busy,
  output logic conv_start,
  output logic irq
);
  seq_state_t state;

  assign load = (state == SEQ_IDLE) && start_req;
  assign run  = (state == SEQ_ACQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      go_busy    <= 1'b0;
      conv_start <= 1'b0;
      irq        <= 1'b0;
    end else if (!adc_en) begin
      state      <= SEQ_IDLE;
      go_busy    <= 1'b0;
      conv_start <= 1'b0;
      irq        <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      irq        <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start_req) begin
            go_busy <= 1'b1;
            if (bypass) begin
              state      <= SEQ_CONV;
              conv_start <= 1'b1;
            end else begin
              state <= SEQ_ACQ;
            end
          end
        end
        SEQ_ACQ: begin
          if (acq_last) begin
            state      <= SEQ_CONV;
            conv_start <= 1'b1;
          end
        end
        SEQ_CONV: begin
          if (conv_done) begin
            state   <= SEQ_IDLE;
            go_busy <= 1'b0;
            irq     <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_trig_pkg::*;
#(
  parameter int ACQ_UNIT   = 2,
  parameter int INSTR_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adc_en,
  input  logic       sw_go,
  input  logic       cmp_evt,
  input  logic [3:0] cmp_mode,
  input  logic       ctu_evt,
  input  logic       ctu_trig_en,
  input  logic       tmr_evt,
  input  logic       rtc_evt,
  input  logic [2:0] acq_sel,
  input  logic       sleep_pending,
  input  logic       conv_done,
  output logic       go_busy,
  output logic       conv_start,
  output logic       tmr_clear,
  output logic       irq
);
  logic cmp_hit, start_req, bypass, acq_last, load, run;

  trig_qualify u_qual (
    .adc_en      (adc_en),
    .sw_go       (sw_go),
    .cmp_evt     (cmp_evt),
    .cmp_mode    (cmp_mode),
    .ctu_evt     (ctu_evt),
    .ctu_trig_en (ctu_trig_en),
    .tmr_evt     (tmr_evt),
    .rtc_evt     (rtc_evt),
    .cmp_hit     (cmp_hit),
    .start_req   (start_req)
  );

  acq_timer #(.ACQ_UNIT(ACQ_UNIT), .INSTR_CLKS(INSTR_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .run    (run),
    .sel    (acq_sel),
    .sleep  (sleep_pending),
    .bypass (bypass),
    .last   (acq_last)
  );

  start_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_en     (adc_en),
    .start_req  (start_req),
    .bypass     (bypass),
    .acq_last   (acq_last),
    .conv_done  (conv_done),
    .load       (load),
    .run        (run),
    .go_busy    (go_busy),
    .conv_start (conv_start),
    .irq        (irq)
  );

  // partner timer clear follows every qualified compare event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_clear <= 1'b0;
    else        tmr_clear <= cmp_hit;
  end
endmodule

// File: rtl/adc_start_ctrl_chk.sv
module adc_start_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       adc_en,
  input logic       cmp_evt,
  input logic [3:0] cmp_mode,
  input logic       tmr_evt,
  input logic       go_busy,
  input logic       conv_start,
  input logic       tmr_clear,
  input logic       irq
);
  p_busy_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !go_busy);

  p_tmr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && cmp_mode == 4'b1011) |=> tmr_clear);

  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_start_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> go_busy);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!go_busy && !$past(irq)));

  p_idle_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_busy && adc_en && tmr_evt) |=> go_busy);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_busy && !adc_en) |=> (!go_busy && !irq && !conv_start));
endmodule

bind adc_start_ctrl adc_start_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_en     (adc_en),
  .cmp_evt    (cmp_evt),
  .cmp_mode   (cmp_mode),
  .tmr_evt    (tmr_evt),
  .go_busy    (go_busy),
  .conv_start (conv_start),
  .tmr_clear  (tmr_clear),
  .irq        (irq)
);

// File: tb/adc_start_ctrl_bench.sv
module adc_start_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT  = 2;
  localparam int INSTR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_en = 1'b0, sw_go = 1'b0, cmp_evt = 1'b0, ctu_evt = 1'b0;
  logic ctu_trig_en = 1'b0, tmr_evt = 1'b0, rtc_evt = 1'b0;
  logic sleep_pending = 1'b0, conv_done = 1'b0;
  logic [3:0] cmp_mode = 4'd0;
  logic [2:0] acq_sel = 3'd0;
  logic go_busy, conv_start, tmr_clear, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_start_ctrl #(.ACQ_UNIT(UNIT), .INSTR_CLKS(INSTR)) u_adc_start_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .sw_go(sw_go),
    .cmp_evt(cmp_evt), .cmp_mode(cmp_mode), .ctu_evt(ctu_evt),
    .ctu_trig_en(ctu_trig_en), .tmr_evt(tmr_evt), .rtc_evt(rtc_evt),
    .acq_sel(acq_sel), .sleep_pending(sleep_pending), .conv_done(conv_done),
    .go_busy(go_busy), .conv_start(conv_start), .tmr_clear(tmr_clear), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: cmp_evt = v;
      1: ctu_evt = v;
      2: tmr_evt = v;
      3: rtc_evt = v;
      default: sw_go = v;
    endcase
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic pulse_src(input int s);
    set_src(s, 1'b1);
    @(negedge clk);
    set_src(s, 1'b0);
  endtask

  task automatic finish_conv();
    int guard = 0;
    while (!conv_start && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_conv(input int s, input int sel, input bit slp);
    int n = 0;
    int exp;
    acq_sel = 3'(sel);
    sleep_pending = slp;
    exp = (sel != 0) ? sel * UNIT : (slp ? INSTR : 0);
    @(negedge clk);
    pulse_src(s);
    sleep_pending = 1'b0;
    check(go_busy == 1'b1, "R2 accept", int'(go_busy), 1);
    while (!conv_start && n < 100) begin @(negedge clk); n++; end
    if (sel != 0)  check(n == exp, "R5 acq latency", n, exp);
    else if (!slp) check(n == exp, "R6 bypass latency", n, exp);
    else           check(n == exp, "R7 sleep delay", n, exp);
    @(negedge clk);
    check(conv_start == 1'b0, "R5 single pulse", int'(conv_start), 0);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check(go_busy == 1'b0 && irq == 1'b1, "R8 done", int'({go_busy, irq}), 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq one cycle", int'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int starts;
    repeat (3) @(negedge clk);
    check({go_busy, conv_start, tmr_clear, irq} == 4'b0, "R1 reset", int'({go_busy, conv_start, tmr_clear, irq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({go_busy, conv_start, tmr_clear, irq} == 4'b0, "R1 after release", int'({go_busy, conv_start, tmr_clear, irq}), 0);

    adc_en = 1'b1; cmp_mode = 4'b1011; ctu_trig_en = 1'b1;
    // full sweep: every source, every acquisition code, sleep on and off
    for (int s = 0; s < 5; s++)
      for (int sel = 0; sel < 8; sel++)
        for (int slp = 0; slp < 2; slp++)
          run_conv(s, sel, slp[0]);

    // compare mode qualifier sweep
    acq_sel = 3'd0;
    for (int m = 0; m < 16; m++) begin
      cmp_mode = 4'(m);
      @(negedge clk);
      pulse_src(0);
      check(go_busy == (m == 11), "R2 cmp mode gate", int'(go_busy), int'(m == 11));
      check(tmr_clear == (m == 11), "R4 timer clear gate", int'(tmr_clear), int'(m == 11));
      if (go_busy) finish_conv();
    end
    cmp_mode = 4'b1011;

    // charge-time enable off
    ctu_trig_en = 1'b0;
    @(negedge clk);
    pulse_src(1);
    check(go_busy == 1'b0, "R2 ctu gated", int'(go_busy), 0);
    ctu_trig_en = 1'b1;

    // converter disabled: every source ignored, timer clear kept
    adc_en = 1'b0;
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      pulse_src(s);
      check(go_busy == 1'b0, "R3 disabled ignore", int'(go_busy), 0);
      if (s == 0) check(tmr_clear == 1'b1, "R4 clear while disabled", int'(tmr_clear), 1);
    end
    @(negedge clk);
    check(conv_start == 1'b0 && irq == 1'b0, "R3 no activity", int'({conv_start, irq}), 0);
    adc_en = 1'b1;

    // all sources together, then more requests while busy
    acq_sel = 3'd3;
    @(negedge clk);
    for (int s = 0; s < 5; s++) set_src(s, 1'b1);
    @(negedge clk);
    for (int s = 0; s < 5; s++) set_src(s, 1'b0);
    starts = 0;
    for (int c = 0; c < 20; c++) begin
      if (conv_start) starts++;
      tmr_evt = (c % 3 == 1); rtc_evt = (c == 4); sw_go = (c == 9);
      cmp_evt = (c == 12);
      @(negedge clk);
      if (c == 12) check(tmr_clear == 1'b1, "R4 clear while busy", int'(tmr_clear), 1);
    end
    tmr_evt = 1'b0; rtc_evt = 1'b0; sw_go = 1'b0; cmp_evt = 1'b0;
    check(starts == 1, "R9 single start", starts, 1);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check(irq == 1'b1 && go_busy == 1'b0, "R8 done after busy", int'({go_busy, irq}), 1);
    repeat (3) @(negedge clk);
    check(go_busy == 1'b0, "R9 no late restart", int'(go_busy), 0);

    // done in idle and during acquisition is ignored
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check(irq == 1'b0, "R8 done idle ignored", int'(irq), 0);
    acq_sel = 3'd7;
    pulse_src(2);
    repeat (2) @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check(irq == 1'b0 && go_busy == 1'b1, "R8 done in acq ignored", int'({go_busy, irq}), 2);
    finish_conv();

    // abort during acquisition
    acq_sel = 3'd5;
    pulse_src(3);
    repeat (3) @(negedge clk);
    adc_en = 1'b0;
    @(negedge clk);
    adc_en = 1'b1;
    check(go_busy == 1'b0 && irq == 1'b0, "R10 abort acq", int'({go_busy, irq}), 0);
    starts = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (conv_start || irq || go_busy) starts++;
    end
    check(starts == 0, "R10 nothing after abort", starts, 0);

    // abort during conversion with done present
    acq_sel = 3'd0;
    pulse_src(4);
    check(conv_start == 1'b1, "R6 immediate start", int'(conv_start), 1);
    adc_en = 1'b0; conv_done = 1'b1;
    @(negedge clk);
    adc_en = 1'b1; conv_done = 1'b0;
    check(go_busy == 1'b0 && irq == 1'b0, "R10 abort conv", int'({go_busy, irq}), 0);
    @(negedge clk);
    check(irq == 1'b0, "R10 no irq later", int'(irq), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule